// File: doc/BRIEF.md
# Interrupt Nesting Level Controller

This block keeps the nesting state of an interrupt controller with ten priority channels and ten host outputs. Channel 0 has the highest priority. A nesting level names the highest-priority channel that is currently blocked. That channel and every channel of lower priority (a higher index) are masked from the prioritizer. There is one global level and one level per host output. A 2-bit mode input selects which level applies and whether hardware updates the levels.

In the automatic modes, the prioritizer reports each taken interrupt through a one-cycle `takeValid` pulse that carries the channel and the host. The relevant level then becomes that channel. Software closes the service window with an `eoiValid` pulse, which returns the level to its idle value 0x100. Software reads and writes every level through a small register port. Address 0 to 9 select the host levels and address 10 selects the global level. Bit 31 of a write is an override flag. It forces the written level in even while hardware owns the level.

The output is one 10-bit channel mask per host output, packed into a single vector.

Top module: `nest_level_ctrl`

## Requirements
- R1: After reset, all eleven levels read 0x100 and `hostMask` is all zeros.
- R2: In mode 0 (off), `hostMask` is all zeros whatever the levels hold.
- R3: For host h, mask bit `hostMask[h*10+c]` is 1 exactly when channel c >= the effective level of that host. The effective level is the host's own level in modes 1 and 3, and the global level in mode 2.
- R4: In mode 1 (automatic per host), `takeValid` with channel c and host h sets host level h to c on the next clock edge. `eoiValid` with host h sets host level h back to 0x100.
- R5: In mode 2 (automatic global), `takeValid` sets the global level to the taken channel and `eoiValid` sets it to 0x100. The host levels do not change.
- R6: In modes 1 and 2, a write with bit 31 = 0 is ignored. A write with bit 31 = 1 loads bits 8:0. An override write wins over a take or release on the same level in the same cycle.
- R7: In modes 0 and 3 (manual), every write to address 0 to 10 loads bits 8:0. Take and release pulses leave all levels unchanged.
- R8: A read at address 0 to 9 returns that host's level, and a read at address 10 returns the global level, both in bits 8:0 with all other bits 0 (bit 31 always reads 0). Addresses 11 to 15 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| nestMode | input | 2 | 0 off, 1 automatic per host, 2 automatic global, 3 manual |
| takeValid | input | 1 | Interrupt taken, one-cycle pulse |
| takeChan | input | 4 | Channel of the taken interrupt |
| takeHost | input | 4 | Host output of the taken interrupt |
| eoiValid | input | 1 | End of service, one-cycle pulse |
| eoiHost | input | 4 | Host output whose service ended |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address (0 to 9 host, 10 global) |
| regWrData | input | 32 | Write data: bit 31 override, bits 8:0 level |
| regRdData | output | 32 | Read data for regAddr, combinational |
| hostMask | output | 100 | Channel masks, host h at bits h*10+9 down to h*10 |

## Verification
Manual mode is swept over every host and every level value 0 to 10, plus the idle value. This shows whether each mask boundary sits at the named channel and not one position off. Per-host automatic mode is swept over every pairing of channel and host, with a release after each take. This separates correct host selection from updates that leak into other hosts. Global mode is driven with takes from varying hosts, to show that only the global level moves. Plain writes, override writes, and override writes that collide with a take tell apart ignored writes, forced writes, and the same-cycle priority between them.

// File: rtl/nest_pkg.sv
package nest_pkg;
  parameter int NEST_HOSTS = 10;
  parameter int NEST_CHANS = 10;
  parameter int LVL_W      = 9;
  localparam int HOST_W    = $clog2(NEST_HOSTS + 1);
  localparam int CHAN_W    = $clog2(NEST_CHANS);
  localparam logic [LVL_W-1:0] LVL_IDLE = LVL_W'(1) << (LVL_W - 1);

  typedef enum logic [1:0] {
    NEST_OFF         = 2'd0,
    NEST_AUTO_HOST   = 2'd1,
    NEST_AUTO_GLOBAL = 2'd2,
    NEST_MANUAL      = 2'd3
  } nestMode_e;

  typedef struct packed {
    logic [NEST_HOSTS-1:0] wrHost;
    logic                  wrGlob;
    logic [LVL_W-1:0]      wrVal;
    logic [NEST_HOSTS-1:0] takeHost;
    logic                  takeGlob;
    logic [LVL_W-1:0]      takeVal;
    logic [NEST_HOSTS-1:0] relHost;
    logic                  relGlob;
  } nestStrobe_t;
endpackage

// File: rtl/nest_ctrl.sv
module nest_ctrl
  import nest_pkg::*;
(
  input  logic [1:0]        nestMode,
  input  logic              takeValid,
  input  logic [CHAN_W-1:0] takeChan,
  input  logic [HOST_W-1:0] takeHost,
  input  logic              eoiValid,
  input  logic [HOST_W-1:0] eoiHost,
  input  logic              regWrEn,
  input  logic [HOST_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output nestStrobe_t       strb
);
  nestMode_e modeSel;
  logic autoHost, autoGlob, wrHit;

  always_comb begin
    modeSel  = nestMode_e'(nestMode);
    autoHost = (modeSel == NEST_AUTO_HOST);
    autoGlob = (modeSel == NEST_AUTO_GLOBAL);
    wrHit    = regWrEn && (!(autoHost || autoGlob) || regWrData[31]);
  end

  always_comb begin
    strb.wrVal    = regWrData[LVL_W-1:0];
    strb.wrGlob   = wrHit && (regAddr == HOST_W'(NEST_HOSTS));
    strb.takeVal  = LVL_W'(takeChan);
    strb.takeGlob = autoGlob && takeValid;
    strb.relGlob  = autoGlob && eoiValid;
  end

  for (genvar h = 0; h < NEST_HOSTS; h++) begin : g_host
    always_comb begin
      strb.wrHost[h]   = wrHit && (regAddr == HOST_W'(h));
      strb.takeHost[h] = autoHost && takeValid && (takeHost == HOST_W'(h));
      strb.relHost[h]  = autoHost && eoiValid && (eoiHost == HOST_W'(h));
    end
  end
endmodule

// File: rtl/nest_datapath.sv
module nest_datapath
  import nest_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [1:0]                     nestMode,
  input  nestStrobe_t                    strb,
  input  logic [HOST_W-1:0]              regAddr,
  output logic [31:0]                    regRdData,
  output logic [NEST_HOSTS*NEST_CHANS-1:0] hostMask
);
  logic [NEST_HOSTS-1:0][LVL_W-1:0] hostLvl;
  logic [LVL_W-1:0] globLvl;

  for (genvar h = 0; h < NEST_HOSTS; h++) begin : g_lvl
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                  hostLvl[h] <= LVL_IDLE;
      else if (strb.wrHost[h])    hostLvl[h] <= strb.wrVal;
      else if (strb.takeHost[h])  hostLvl[h] <= strb.takeVal;
      else if (strb.relHost[h])   hostLvl[h] <= LVL_IDLE;
    end

    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rstN)
      strb.wrHost[h] |=> hostLvl[h] == $past(strb.wrVal)); // R6
    AST_TAKE_LOADS: assert property (@(posedge clk) disable iff (!rstN)
      (strb.takeHost[h] && !strb.wrHost[h]) |=> hostLvl[h] == $past(strb.takeVal)); // R4
    AST_RELEASE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
      (strb.relHost[h] && !strb.takeHost[h] && !strb.wrHost[h]) |=> hostLvl[h] == LVL_IDLE); // R4

    logic [LVL_W-1:0] effLvl;
    always_comb effLvl = (nestMode == NEST_AUTO_GLOBAL) ? globLvl : hostLvl[h];

    for (genvar c = 0; c < NEST_CHANS; c++) begin : g_chan
      always_comb hostMask[h*NEST_CHANS + c] =
        (nestMode != NEST_OFF) && (LVL_W'(c) >= effLvl);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              globLvl <= LVL_IDLE;
    else if (strb.wrGlob)   globLvl <= strb.wrVal;
    else if (strb.takeGlob) globLvl <= strb.takeVal;
    else if (strb.relGlob)  globLvl <= LVL_IDLE;
  end

  always_comb begin
    regRdData = '0;
    for (int h = 0; h < NEST_HOSTS; h++)
      if (regAddr == HOST_W'(h)) regRdData[LVL_W-1:0] = hostLvl[h];
    if (regAddr == HOST_W'(NEST_HOSTS)) regRdData[LVL_W-1:0] = globLvl;
  end

  AST_GLOB_TAKE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.takeGlob && !strb.wrGlob) |=> globLvl == $past(strb.takeVal)); // R5
  AST_OFF_UNMASKED: assert property (@(posedge clk) disable iff (!rstN)
    (nestMode == NEST_OFF) |-> hostMask == '0); // R2
  AST_MANUAL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (nestMode == NEST_MANUAL && strb.wrHost == '0 && !strb.wrGlob)
      |=> ($stable(hostLvl) && $stable(globLvl))); // R7
  AST_RESERVED_READ: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr > HOST_W'(NEST_HOSTS)) |-> regRdData == '0); // R8
endmodule

// File: rtl/nest_level_ctrl.sv
module nest_level_ctrl
  import nest_pkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [1:0]                       nestMode,
  input  logic                             takeValid,
  input  logic [CHAN_W-1:0]                takeChan,
  input  logic [HOST_W-1:0]                takeHost,
  input  logic                             eoiValid,
  input  logic [HOST_W-1:0]                eoiHost,
  input  logic                             regWrEn,
  input  logic [HOST_W-1:0]                regAddr,
  input  logic [31:0]                      regWrData,
  output logic [31:0]                      regRdData,
  output logic [NEST_HOSTS*NEST_CHANS-1:0] hostMask
);
  nestStrobe_t strb;

  nest_ctrl u_ctrl (
    .nestMode (nestMode),
    .takeValid(takeValid),
    .takeChan (takeChan),
    .takeHost (takeHost),
    .eoiValid (eoiValid),
    .eoiHost  (eoiHost),
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .strb     (strb)
  );

  nest_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .nestMode (nestMode),
    .strb     (strb),
    .regAddr  (regAddr),
    .regRdData(regRdData),
    .hostMask (hostMask)
  );
endmodule

// File: tb/sim_nest_level_ctrl.sv
module sim_nest_level_ctrl;
  logic clk = 0, rstN = 0;
  logic [1:0] nestMode = 0;
  logic takeValid = 0, eoiValid = 0, regWrEn = 0;
  logic [3:0] takeChan = 0, takeHost = 0, eoiHost = 0, regAddr = 0;
  logic [31:0] regWrData = 0, regRdData;
  logic [99:0] hostMask;

  int checks = 0, errors = 0, curMode = 0;
  logic [8:0] expLvl [0:10];

  always #10 clk = ~clk;

  nest_level_ctrl u0 (.*);

  task automatic fail(string req, logic [127:0] act, logic [127:0] exp);
    errors++;
    $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
  endtask

  task automatic setMode(int m);
    @(negedge clk); nestMode = 2'(m); curMode = m; #1;
  endtask

  function automatic bit writeTakes(int addr, logic [31:0] d);
    return addr <= 10 && (curMode == 0 || curMode == 3 || d[31]);
  endfunction

  task automatic wrReg(int addr, logic [31:0] d);
    @(negedge clk); regWrEn = 1; regAddr = 4'(addr); regWrData = d;
    @(negedge clk); regWrEn = 0; regWrData = 0;
    if (writeTakes(addr, d)) expLvl[addr] = d[8:0];
  endtask

  task automatic modelTake(int c, int h);
    if (curMode == 1) expLvl[h] = 9'(c);
    else if (curMode == 2) expLvl[10] = 9'(c);
  endtask

  task automatic take(int c, int h);
    @(negedge clk); takeValid = 1; takeChan = 4'(c); takeHost = 4'(h);
    @(negedge clk); takeValid = 0;
    modelTake(c, h);
  endtask

  task automatic eoi(int h);
    @(negedge clk); eoiValid = 1; eoiHost = 4'(h);
    @(negedge clk); eoiValid = 0;
    if (curMode == 1) expLvl[h] = 9'h100;
    else if (curMode == 2) expLvl[10] = 9'h100;
  endtask

  task automatic takeAndWrite(int c, int h, int addr, logic [31:0] d);
    @(negedge clk); takeValid = 1; takeChan = 4'(c); takeHost = 4'(h);
    regWrEn = 1; regAddr = 4'(addr); regWrData = d;
    @(negedge clk); takeValid = 0; regWrEn = 0; regWrData = 0;
    modelTake(c, h);
    if (writeTakes(addr, d)) expLvl[addr] = d[8:0];
  endtask

  task automatic chkRead(int addr, string req);
    logic [31:0] exp;
    regAddr = 4'(addr); #1;
    exp = (addr <= 10) ? {23'd0, expLvl[addr]} : 32'd0;
    checks++;
    if (regRdData !== exp) fail(req, 128'(regRdData), 128'(exp));
  endtask

  task automatic chkMask(string req);
    logic [99:0] exp;
    int eff;
    for (int h = 0; h < 10; h++) begin
      eff = (curMode == 2) ? int'(expLvl[10]) : int'(expLvl[h]);
      for (int c = 0; c < 10; c++) exp[h*10+c] = (curMode != 0) && (c >= eff);
    end
    #1; checks++;
    if (hostMask !== exp) fail(req, 128'(hostMask), 128'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i <= 10; i++) expLvl[i] = 9'h100;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    for (int a = 0; a <= 10; a++) chkRead(a, "R1");
    chkMask("R1");

    // R3 / R7 manual sweep over every host and level
    setMode(3);
    for (int h = 0; h < 10; h++)
      for (int l = 0; l <= 11; l++) begin
        wrReg(h, (l == 11) ? 32'h100 : 32'(l));
        chkRead(h, "R7");
        chkMask("R3");
      end
    for (int h = 0; h < 10; h++) wrReg(h, 32'(h));
    chkMask("R3");

    // R2 off mode masks nothing
    setMode(0);
    chkMask("R2");
    checks++; if (hostMask !== '0) fail("R2", 128'(hostMask), 0);
    wrReg(2, 32'd5); chkRead(2, "R7"); chkMask("R2");

    // R7 manual mode ignores take and release
    setMode(3);
    take(3, 4); chkRead(4, "R7");
    eoi(4); chkRead(4, "R7");
    wrReg(10, 32'd7); chkRead(10, "R7");
    for (int h = 0; h < 10; h++) wrReg(h, 32'h100);

    // R4 automatic per-host sweep
    setMode(1);
    for (int h = 0; h < 10; h++)
      for (int c = 0; c < 10; c++) begin
        take(c, h);
        chkRead(h, "R4"); chkMask("R3");
        eoi(h);
        chkRead(h, "R4");
      end
    // R6 plain write ignored, override loads, bit31 reads 0
    wrReg(5, 32'd2); chkRead(5, "R6");
    wrReg(5, 32'h8000_0002); chkRead(5, "R6"); chkMask("R6");
    takeAndWrite(7, 5, 5, 32'h8000_0001); chkRead(5, "R6");
    takeAndWrite(8, 6, 5, 32'h8000_0004); chkRead(5, "R6"); chkRead(6, "R4");
    chkMask("R3");
    for (int h = 0; h < 10; h++) eoi(h);

    // R5 automatic global
    setMode(2);
    wrReg(3, 32'h8000_0009);
    for (int c = 0; c < 10; c++) begin
      take(c, (c * 3) % 10);
      chkRead(10, "R5"); chkRead((c * 3) % 10, "R5"); chkMask("R3");
    end
    eoi(0); chkRead(10, "R5"); chkRead(3, "R5"); chkMask("R5");
    wrReg(10, 32'd4); chkRead(10, "R6");
    wrReg(10, 32'h8000_0004); chkRead(10, "R6"); chkMask("R3");

    // R8 reserved addresses
    setMode(3);
    for (int a = 11; a < 16; a++) chkRead(a, "R8");
    wrReg(12, 32'd3); wrReg(15, 32'h8000_0001);
    for (int a = 0; a < 16; a++) chkRead(a, "R8");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule